// File: doc/BRIEF.md
# Chainable FIFO Slice Controller

This block is the control half of one FIFO slice: it owns the write and read pointers, the fill count, the full/empty/half flags and the gating of the local access strobes. The storage array sits outside and is addressed by `wr_addr` and `rd_addr`, written when `wr_en` is high and read when `rd_en` is high.

With `chained` low the slice is a standalone FIFO. Retransmit rewinds the read side to the start, and the shared output `xo_hf` reports that more than half of the slice is occupied.

With `chained` high, several slices form a ring that acts as one deeper buffer. Each slice has a write token and a read token. A slice accepts writes, or reads, only while it holds the matching token. When a slice writes its last location it raises `xo_hf` for that cycle. That pulse goes to the next slice's `xi_wr`, which takes the write token at the same clock edge, while the sender gives it up. Reads pass the read token the same way through `xo_rd`/`xi_rd`. The slice whose `first_n` is low at reset starts with both tokens.

Top module: `fifo_chain_ctrl`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) clears both pointers and the count, so `empty`=1 and `full`=0. In chained mode the slice with `first_n`=0 then holds both tokens, and every other slice holds neither.
- R2: `wr_en` is high when `wr_req` is high, the slice is not full and (in chained mode) it holds the write token. `full` goes high once the slice stores DEPTH entries, and further writes are then refused.
- R3: `rd_en` is high when `rd_req` is high, the slice is not empty and (in chained mode) it holds the read token. Addresses advance by one per access and wrap, so data leaves in write order.
- R4: In single mode `xo_hf` is high exactly while the count exceeds DEPTH/2, and `xo_rd` stays low.
- R5: In single mode a cycle with `rt_req` high blocks both accesses and sets `rd_addr` to 0. The count becomes the number of entries written since reset, which is valid when fewer than DEPTH writes were made, or when the slice is full and has not been read.
- R6: In chained mode a slice without the write token never raises `wr_en`, and a slice without the read token never raises `rd_en`.
- R7: In chained mode `xo_hf` is high for exactly the cycle in which a write goes to address DEPTH-1. At that edge the sender releases the write token and the slice seeing `xi_wr` high gains it.
- R8: In chained mode `xo_rd` is high for exactly the cycle in which a read comes from address DEPTH-1, and the read token moves in the same way through `xi_rd`.
- R9: In chained mode `rt_req` has no effect: `rd_addr` and the stored order are unchanged.
- R10: A ring of N slices stores N*DEPTH entries in total, returns them in write order and then reports empty. The tokens continue round the ring for later traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chained | input | 1 | 1 = ring (chained) mode, 0 = single-slice mode |
| first_n | input | 1 | Low marks the slice holding both tokens after reset |
| wr_req | input | 1 | Write request |
| rd_req | input | 1 | Read request |
| rt_req | input | 1 | Retransmit request (single mode only) |
| xi_wr | input | 1 | Write-token pulse from the previous slice |
| xi_rd | input | 1 | Read-token pulse from the previous slice |
| wr_en | output | 1 | Gated write strobe to storage |
| rd_en | output | 1 | Gated read strobe to storage |
| wr_addr | output | AW | Storage write address |
| rd_addr | output | AW | Storage read address |
| full | output | 1 | Slice holds DEPTH entries |
| empty | output | 1 | Slice holds no entries |
| xo_hf | output | 1 | Chained: write-token pulse out; single: half-full flag |
| xo_rd | output | 1 | Chained: read-token pulse out; single: low |

## Verification
The bench attacks token handover at slice boundaries. A handover that is one cycle late, or that goes to the wrong slice, shows up as a refused or misplaced access at entry DEPTH or 2*DEPTH. The bench also fills the whole ring. The wrap back to a slice that is still full must be refused; a design that ignored the local count there would overwrite the oldest data. A retransmit in chained mode must leave the read order intact, and a single-mode rewind must replay exactly the entries written. The half-full threshold is probed on both sides of DEPTH/2, to catch a comparison that is off by one.

// File: rtl/fifo_chain_ctrl.sv
module fifo_chain_ctrl #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1,
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chained,
  input  logic          first_n,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic          rt_req,
  input  logic          xi_wr,
  input  logic          xi_rd,
  output logic          wr_en,
  output logic          rd_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          full,
  output logic          empty,
  output logic          xo_hf,
  output logic          xo_rd
);

  logic [CW-1:0] cnt;
  logic wtok, rtok;

  wire rt_go  = rt_req & ~chained;
  wire w_own  = ~chained | wtok;
  wire r_own  = ~chained | rtok;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign wr_en = wr_req & w_own & ~full & ~rt_go;
  assign rd_en = rd_req & r_own & ~empty & ~rt_go;

  wire w_last = wr_en & (wr_addr == AW'(DEPTH - 1));
  wire r_last = rd_en & (rd_addr == AW'(DEPTH - 1));

  assign xo_hf = chained ? w_last : (cnt > CW'(HALF));
  assign xo_rd = chained & r_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_addr <= '0;
      rd_addr <= '0;
      cnt     <= '0;
      wtok    <= chained & ~first_n;
      rtok    <= chained & ~first_n;
    end else begin
      if (rt_go) begin
        rd_addr <= '0;
        cnt     <= full ? CW'(DEPTH) : {1'b0, wr_addr};
      end else begin
        wr_addr <= wr_addr + AW'(wr_en);
        rd_addr <= rd_addr + AW'(rd_en);
        cnt     <= cnt + CW'(wr_en) - CW'(rd_en);
      end
      if (chained) begin
        if (xi_wr)       wtok <= 1'b1;
        else if (w_last) wtok <= 1'b0;
        if (xi_rd)       rtok <= 1'b1;
        else if (r_last) rtok <= 1'b0;
      end
    end
  end

  initial a_r10_depth_pow2: assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0);

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r2_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !rd_en |=> cnt == $past(cnt) + 1'b1);
  a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en |=> cnt == $past(cnt) - 1'b1);
  a_r4_half_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !chained && xo_hf |-> !empty);
  a_r5_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    !chained && rt_req |=> rd_addr == '0);
  a_r7_wtok_gain: assert property (@(posedge clk) disable iff (!rst_n)
    chained && xi_wr |=> wtok);
  a_r7_wtok_drop: assert property (@(posedge clk) disable iff (!rst_n)
    chained && xo_hf && !xi_wr |=> !wtok);
  a_r8_rtok_drop: assert property (@(posedge clk) disable iff (!rst_n)
    chained && xo_rd && !xi_rd |=> !rtok);
  a_r9_rt_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    chained && rt_req && !rd_en |=> $stable(rd_addr));

endmodule

// File: tb/fifo_chain_ctrl_tb_top.sv
module fifo_chain_ctrl_tb_top;
  localparam int D = 8;
  localparam int AW = 3;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chained = 1'b0;
  logic wr_req = 1'b0, rd_req = 1'b0, rt_req = 1'b0;
  logic [7:0] din = '0;
  logic [N-1:0] first_n = 3'b110;
  logic [N-1:0] we, re, fl, em, xw, xr;
  logic [AW-1:0] wa [N];
  logic [AW-1:0] ra [N];
  logic [7:0] mem [N][D];

  int total = 0, bad = 0;
  logic [N-1:0] s_we, s_re, s_xw, s_xr, s_fl, s_em;
  int s_rd, s_ra0;

  always #4 clk = ~clk;

  for (genvar i = 0; i < N; i++) begin : g
    fifo_chain_ctrl #(.DEPTH(D)) dut_i (
      .clk(clk), .rst_n(rst_n), .chained(chained), .first_n(first_n[i]),
      .wr_req(wr_req), .rd_req(rd_req), .rt_req(rt_req),
      .xi_wr(xw[(i+N-1)%N]), .xi_rd(xr[(i+N-1)%N]),
      .wr_en(we[i]), .rd_en(re[i]), .wr_addr(wa[i]), .rd_addr(ra[i]),
      .full(fl[i]), .empty(em[i]), .xo_hf(xw[i]), .xo_rd(xr[i]));
  end

  always @(posedge clk)
    for (int k = 0; k < N; k++) if (we[k]) mem[k][wa[k]] <= din;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit w, input bit r, input bit rt, input int d);
    @(negedge clk);
    wr_req = w; rd_req = r; rt_req = rt; din = d[7:0];
    #1;
    s_we = we; s_re = re; s_xw = xw; s_xr = xr; s_fl = fl; s_em = em;
    s_ra0 = ra[0];
    s_rd = -1;
    for (int k = 0; k < N; k++) if (re[k]) s_rd = mem[k][ra[k]];
    @(posedge clk);
    #1;
    wr_req = 0; rd_req = 0; rt_req = 0;
  endtask

  task automatic do_reset(input bit mode);
    @(negedge clk);
    chained = mode; rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset;
    do_reset(1);
    @(negedge clk);
    chk(em == 3'b111, "R1 empty after reset", em, 7);
    chk(fl == 3'b000, "R1 full after reset", fl, 0);
    wr_req = 1; rd_req = 1; #1;
    chk(we == 3'b001, "R1 R6 write token at first slice", we, 1);
    chk(re == 3'b000, "R3 no read while empty", re, 0);
    wr_req = 0; rd_req = 0;
  endtask

  task automatic t_single_fill;
    do_reset(0);
    for (int i = 0; i < D; i++) begin
      cyc(1, 0, 0, 100 + i);
      chk(s_we[0], "R2 write accepted", s_we[0], 1);
      chk(s_xr[0] == 0, "R4 xo_rd low in single", s_xr[0], 0);
      if (i == D/2 - 1) begin
        cyc(0, 0, 0, 0);
        chk(s_xw[0] == 0, "R4 half flag at D/2", s_xw[0], 0);
      end
      if (i == D/2) begin
        cyc(0, 0, 0, 0);
        chk(s_xw[0] == 1, "R4 half flag above D/2", s_xw[0], 1);
      end
    end
    cyc(1, 0, 0, 7);
    chk(s_fl[0] == 1, "R2 full after DEPTH writes", s_fl[0], 1);
    chk(s_we[0] == 0, "R2 write refused when full", s_we[0], 0);
    for (int i = 0; i < D; i++) begin
      cyc(0, 1, 0, 0);
      chk(s_re[0] && s_rd == 100 + i, "R3 read order", s_rd, 100 + i);
    end
    cyc(0, 1, 0, 0);
    chk(s_re[0] == 0 && s_em[0], "R3 read refused when empty", s_re[0], 0);
  endtask

  task automatic t_single_rt;
    do_reset(0);
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 10 + i);
    cyc(0, 1, 0, 0);
    cyc(0, 1, 0, 0);
    cyc(1, 1, 1, 55);
    chk(s_we[0] == 0 && s_re[0] == 0, "R5 access blocked during retransmit",
        {s_we[0], s_re[0]}, 0);
    cyc(0, 0, 0, 0);
    chk(s_ra0 == 0, "R5 rd_addr rewound", s_ra0, 0);
    for (int i = 0; i < 3; i++) begin
      cyc(0, 1, 0, 0);
      chk(s_rd == 10 + i, "R5 replay order", s_rd, 10 + i);
    end
    cyc(0, 1, 0, 0);
    chk(s_re[0] == 0, "R5 empty after replay", s_re[0], 0);
  endtask

  task automatic t_chain;
    do_reset(1);
    for (int i = 0; i < N*D; i++) begin
      cyc(1, 0, 0, i + 1);
      chk(s_we == 3'(1 << (i / D)), "R6 write slice", s_we, 1 << (i / D));
      chk(s_xw == ((i % D == D-1) ? 3'(1 << (i / D)) : 3'b000),
          "R7 write token pulse", s_xw, (i % D == D-1) ? (1 << (i / D)) : 0);
    end
    cyc(1, 0, 0, 99);
    chk(s_we == 0, "R10 ring full refuses write", s_we, 0);
    cyc(0, 1, 0, 0);
    chk(s_re == 3'b001 && s_rd == 1, "R6 first read", s_rd, 1);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 0, 0);
    chk(s_ra0 == 1, "R9 retransmit ignored", s_ra0, 1);
    for (int i = 1; i < N*D; i++) begin
      cyc(0, 1, 0, 0);
      chk(s_re == 3'(1 << (i / D)), "R6 read slice", s_re, 1 << (i / D));
      chk(s_rd == i + 1, "R10 ring read order", s_rd, i + 1);
      chk(s_xr == ((i % D == D-1) ? 3'(1 << (i / D)) : 3'b000),
          "R8 read token pulse", s_xr, (i % D == D-1) ? (1 << (i / D)) : 0);
    end
    cyc(0, 1, 0, 0);
    chk(s_re == 0, "R10 ring empty", s_re, 0);
    cyc(1, 0, 0, 77);
    chk(s_we == 3'b001, "R10 write token wrapped", s_we, 1);
    cyc(0, 1, 0, 0);
    chk(s_re == 3'b001 && s_rd == 77, "R10 read token wrapped", s_rd, 77);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_single_fill();
    t_single_rt();
    t_chain();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule